// File: doc/BRIEF.md
# Serial Control-Register Port with Detection Interrupt

This block lets a microcontroller reach a bank of byte-wide control registers over a four-wire serial link: a select input, a shift clock, a serial data input and a serial data output that is high-impedance whenever it is not returning read data. Each frame is a direction bit, a five-bit register address and eight data bits, all most significant bit first. All three serial inputs are brought into the system clock domain through two-flop synchronisers. Bits are taken on the synchronised rising edges of the shift clock, so the shift clock must run several times slower than the system clock.

One address holds a read-only status byte assembled from detector inputs. When the call-progress or tone detection result changes, an active-low interrupt output is latched low. It stays low until software reads the status byte. A power-down/reset input, or a reset bit in register 0, puts every register back to its initial value and releases the interrupt.

Top module: `ctlreg_serial_port`

## Requirements
- R1: A frame starts when `sel` is high. The first sampled bit is the direction (1 = read, 0 = write), followed by address bits A4..A0. Bits are sampled on rising edges of `sclk`.
- R2: On a write, data bits B7..B0 follow the address. After the 14th edge, the addressed register holds that byte, and a later read returns it.
- R3: On a read, `sdo` presents B7 after the 6th edge and moves to the next lower bit after each of edges 7 to 13. It is high-impedance while idle, during the direction and address bits, and after the 14th edge.
- R4: Registers live at addresses 0..16. Addresses 17..31 read as 0x00 and ignore writes.
- R5: Address 7 is read-only status: bits 7:5 = `det_hi`, bit 4 = current `irq_n` level, bit 3 = `det_cpt`, bit 2 = `det_tone`, bits 1:0 = `det_lo`. A write to address 7 has no effect.
- R6: `irq_n` goes low the clock after `det_cpt` or `det_tone` differs from its value on the previous clock (taken as 0 after `rst_n`).
- R7: `irq_n` stays low until a status read reaches its address phase, then returns high. That read reports bit 4 = 0. If a change arrives in the same cycle, the set wins.
- R8: While `pdrst_n` is low, all registers hold their initial values (address 8 = 0x80, all others 0x00), `irq_n` is high, and writes are ignored.
- R9: A write to address 0 with bit 5 set has the same effect as R8 for one cycle; register 0 then reads 0x00.
- R10: Dropping `sel` before the 14th edge abandons the frame: no register changes, and `sdo` returns to high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| pdrst_n | input | 1 | Synchronous active-low power-down reset of the register bank |
| sel | input | 1 | Frame select, active high, asynchronous |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high-impedance when not returning read data |
| irq_n | output | 1 | Active-low latched detection-change interrupt |
| det_cpt | input | 1 | Call-progress detection result |
| det_tone | input | 1 | Tone detection result |
| det_hi | input | 3 | Other status bits shown in status bits 7:5 |
| det_lo | input | 2 | Other status bits shown in status bits 1:0 |

## Verification
A bit-counter fault shows up as a byte rotated by one place, or as `sdo` driving during the address phase. Either appears on the very next read frame. A wrong interrupt latch appears on `irq_n` within two clocks of a detector toggle, or on the first status read, whose bit 4 then disagrees with the pin. A bank that misses a reset path is only exposed by a read after `pdrst_n` or after the soft-reset write, so every reset scenario ends with read-backs of address 8 and of a previously written register.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;

  // value a register takes after any reset
  function automatic logic [DATA_W-1:0] reg_init(input int idx, input int echo_idx);
    return (idx == echo_idx) ? 8'h80 : 8'h00;
  endfunction

  // status byte layout; bits 3 and 2 are the interrupt sources
  function automatic logic [DATA_W-1:0] status_pack(input logic [2:0] hi, input logic irq_lvl,
                                                    input logic cpt, input logic tone,
                                                    input logic [1:0] lo);
    return {hi, irq_lvl, cpt, tone, lo};
  endfunction
endpackage

// File: rtl/ctlreg_sync.sv
module ctlreg_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ctlreg_frame.sv
module ctlreg_frame
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_commit,
  output logic              rd_start,
  output logic              frame_abort,
  output logic              sdo_oe,
  output logic              sdo_bit
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] sh;
  logic [DATA_W-1:0] tx;
  logic              rw, sclk_d, sel_d, ld_pend;
  logic              rise, sel_fall;

  assign rise        = sclk_s & ~sclk_d;
  assign sel_fall    = sel_d & ~sel_s;
  assign frame_abort = sel_fall && (cnt != '0) && (cnt != CNT_DONE);
  assign rd_start    = ld_pend;
  assign sdo_bit     = tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; tx <= '0; rw <= 1'b0;
      sclk_d <= 1'b0; sel_d <= 1'b0; ld_pend <= 1'b0;
      addr <= '0; wr_data <= '0; wr_commit <= 1'b0; sdo_oe <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      sel_d     <= sel_s;
      wr_commit <= 1'b0;
      ld_pend   <= 1'b0;
      if (!sel_s) begin
        cnt    <= '0;
        sdo_oe <= 1'b0;
      end else begin
        if (ld_pend) begin
          tx     <= rd_data;
          sdo_oe <= 1'b1;
        end
        if (rise && cnt != CNT_DONE) begin
          cnt <= cnt + 1'b1;
          sh  <= {sh[DATA_W-3:0], sdi_s};
          if (cnt == '0) rw <= sdi_s;
          if (cnt == CNT_ADDR) begin
            addr    <= {sh[ADDR_W-2:0], sdi_s};
            ld_pend <= rw;
          end
          if (cnt > CNT_ADDR && cnt < CNT_LAST) tx <= tx << 1;
          if (cnt == CNT_LAST) begin
            sdo_oe <= 1'b0;
            if (!rw) begin
              wr_commit <= 1'b1;
              wr_data   <= {sh, sdi_s};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int NUM_REGS = 17,
  parameter int STAT_IDX = 7,
  parameter int ECHO_IDX = 8,
  parameter int SRST_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdrst_n,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] stat_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              soft_rst
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              wr_en, clr_all;

  assign wr_en    = wr_commit && pdrst_n;
  assign soft_rst = wr_en && (addr == '0) && wr_data[SRST_BIT];
  assign clr_all  = !pdrst_n || soft_rst;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (gi == STAT_IDX) begin : g_stat
      assign regs[gi] = stat_byte;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  q <= reg_init(gi, ECHO_IDX);
        else if (clr_all)                            q <= reg_init(gi, ECHO_IDX);
        else if (wr_en && addr == ADDR_W'(gi))       q <= wr_data;
      end
      assign regs[gi] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/ctlreg_irq.sv
module ctlreg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic det_a,
  input  logic det_b,
  input  logic stat_rd,
  output logic det_chg,
  output logic irq_n
);
  logic prev_a, prev_b, pending;

  assign det_chg = (det_a != prev_a) || (det_b != prev_b);
  assign irq_n   = ~pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= 1'b0; prev_b <= 1'b0; pending <= 1'b0;
    end else begin
      prev_a <= det_a;
      prev_b <= det_b;
      if (clr)          pending <= 1'b0;
      else if (det_chg) pending <= 1'b1;
      else if (stat_rd) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/ctlreg_serial_port.sv
module ctlreg_serial_port
  import ctlreg_pkg::*;
#(
  parameter int NUM_REGS = 17,
  parameter int STAT_IDX = 7,
  parameter int ECHO_IDX = 8,
  parameter int SRST_BIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdrst_n,
  input  logic       sel,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       irq_n,
  input  logic       det_cpt,
  input  logic       det_tone,
  input  logic [2:0] det_hi,
  input  logic [1:0] det_lo
);
  logic              sel_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_data, stat_byte;
  logic              wr_commit, rd_start, frame_abort, sdo_oe, sdo_bit;
  logic              soft_rst, stat_rd, det_chg, irq_clr;

  ctlreg_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel, sclk, sdi}), .q({sel_s, sclk_s, sdi_s})
  );

  ctlreg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .addr(addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .rd_start(rd_start), .frame_abort(frame_abort), .sdo_oe(sdo_oe), .sdo_bit(sdo_bit)
  );

  assign stat_byte = status_pack(det_hi, irq_n, det_cpt, det_tone, det_lo);

  ctlreg_bank #(
    .NUM_REGS(NUM_REGS), .STAT_IDX(STAT_IDX), .ECHO_IDX(ECHO_IDX), .SRST_BIT(SRST_BIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .pdrst_n(pdrst_n), .wr_commit(wr_commit), .addr(addr),
    .wr_data(wr_data), .stat_byte(stat_byte), .rd_data(rd_data), .soft_rst(soft_rst)
  );

  assign stat_rd = rd_start && (addr == ADDR_W'(STAT_IDX));
  assign irq_clr = !pdrst_n || soft_rst;

  ctlreg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .clr(irq_clr), .det_a(det_cpt), .det_b(det_tone),
    .stat_rd(stat_rd), .det_chg(det_chg), .irq_n(irq_n)
  );

  assign sdo = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/ctlreg_serial_port_chk.sv
module ctlreg_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic pdrst_n,
  input logic irq_n,
  input logic det_chg,
  input logic stat_rd,
  input logic soft_rst,
  input logic sel_s,
  input logic sdo_oe,
  input logic wr_commit,
  input logic rd_start,
  input logic frame_abort
);
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (det_chg && pdrst_n && !soft_rst) |=> !irq_n); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !stat_rd && pdrst_n && !soft_rst) |=> !irq_n); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !det_chg) |=> irq_n); // R7
  AST_PDRST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !pdrst_n |=> irq_n); // R8
  AST_SOFT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> irq_n); // R9
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !sdo_oe); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_commit, rd_start, frame_abort})); // R1
endmodule

bind ctlreg_serial_port ctlreg_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pdrst_n(pdrst_n), .irq_n(irq_n), .det_chg(det_chg),
  .stat_rd(stat_rd), .soft_rst(soft_rst), .sel_s(sel_s), .sdo_oe(sdo_oe),
  .wr_commit(wr_commit), .rd_start(rd_start), .frame_abort(frame_abort)
);

// File: tb/ctlreg_serial_port_tb.sv
module ctlreg_serial_port_tb;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, pdrst_n = 1'b1;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic det_cpt = 1'b0, det_tone = 1'b0;
  logic [2:0] det_hi = '0;
  logic [1:0] det_lo = '0;
  wire  sdo, irq_n;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ctlreg_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .pdrst_n(pdrst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .irq_n(irq_n), .det_cpt(det_cpt), .det_tone(det_tone),
    .det_hi(det_hi), .det_lo(det_lo)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits < 14 abandons the frame; rd collects the sdo bits; zmid records sdo during the address
  task automatic frame(input bit rw, input logic [4:0] a, input logic [7:0] d, input int nbits,
                       output logic [7:0] rd, output logic zmid);
    logic [13:0] bits;
    bits = {rw, a, d};
    rd = 'x; zmid = 1'b0;
    sel = 1'b1; wt(H);
    for (int p = 0; p < nbits; p++) begin
      if (p >= 6) rd[13-p] = sdo;
      if (p == 3) zmid = sdo;
      sdi = bits[13-p];
      wt(H); sclk = 1'b1; wt(H); sclk = 1'b0; wt(H);
    end
    sel = 1'b0; wt(2*H);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r; logic z;
    frame(1'b0, a, d, 14, r, z);
  endtask

  task automatic rdchk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] r; logic z;
    frame(1'b1, a, 8'h00, 14, r, z);
    chk(req, r, exp);
  endtask

  function automatic logic [7:0] stat_exp(input logic irq_lvl);
    return {det_hi, irq_lvl, det_cpt, det_tone, det_lo};
  endfunction

  task automatic t_reset;
    chk("R8 irq_n idle", {7'b0, irq_n}, 8'h01);
    chk("R3 sdo idle z", {7'b0, sdo}, {7'b0, 1'bz});
    rdchk("R8 reg0 init", 5'd0, 8'h00);
    rdchk("R8 reg8 init", 5'd8, 8'h80);
    rdchk("R4 reg16 init", 5'd16, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] r; logic z;
    wr(5'd3, 8'hA5); wr(5'd4, 8'h3C); wr(5'd16, 8'h81); wr(5'd8, 8'h01);
    rdchk("R2 reg3", 5'd3, 8'hA5);
    rdchk("R2 reg4", 5'd4, 8'h3C);
    rdchk("R4 reg16 writable", 5'd16, 8'h81);
    rdchk("R1 reg8", 5'd8, 8'h01);
    frame(1'b1, 5'd3, 8'h00, 14, r, z);
    chk("R3 read bits", r, 8'hA5);
    chk("R3 z during address", {7'b0, z}, {7'b0, 1'bz});
    chk("R3 z after frame", {7'b0, sdo}, {7'b0, 1'bz});
  endtask

  task automatic t_out_of_range;
    wr(5'd20, 8'hFF);
    rdchk("R4 addr20 reads 0", 5'd20, 8'h00);
    rdchk("R4 addr31 reads 0", 5'd31, 8'h00);
    rdchk("R4 reg4 untouched", 5'd4, 8'h3C);
  endtask

  task automatic t_status;
    det_hi = 3'b101; det_lo = 2'b10; wt(4);
    rdchk("R5 status layout", 5'd7, stat_exp(1'b1));
    wr(5'd7, 8'h00);
    rdchk("R5 status read-only", 5'd7, stat_exp(1'b1));
  endtask

  task automatic t_irq;
    det_cpt = 1'b1; wt(2);
    chk("R6 irq on cpt change", {7'b0, irq_n}, 8'h00);
    wt(60);
    chk("R7 irq held", {7'b0, irq_n}, 8'h00);
    rdchk("R7 status shows pending", 5'd7, stat_exp(1'b0));
    chk("R7 irq cleared by read", {7'b0, irq_n}, 8'h01);
    rdchk("R7 status after clear", 5'd7, stat_exp(1'b1));
    det_tone = 1'b1; wt(2);
    chk("R6 irq on tone change", {7'b0, irq_n}, 8'h00);
    rdchk("R7 other reg keeps irq", 5'd3, 8'hA5);
    chk("R7 non-status read", {7'b0, irq_n}, 8'h00);
    rdchk("R7 status read", 5'd7, stat_exp(1'b0));
    chk("R7 cleared again", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_pdrst;
    det_cpt = 1'b0; wt(2);
    chk("R6 irq on fall", {7'b0, irq_n}, 8'h00);
    pdrst_n = 1'b0; wt(2);
    chk("R8 irq released", {7'b0, irq_n}, 8'h01);
    wr(5'd5, 8'h77);
    pdrst_n = 1'b1; wt(2);
    rdchk("R8 write ignored", 5'd5, 8'h00);
    rdchk("R8 reg3 cleared", 5'd3, 8'h00);
    rdchk("R8 reg8 back to 80", 5'd8, 8'h80);
  endtask

  task automatic t_softrst;
    wr(5'd3, 8'h5A); wr(5'd8, 8'h11); wr(5'd0, 8'h0F);
    rdchk("R9 reg0 plain write", 5'd0, 8'h0F);
    det_tone = 1'b0; wt(2);
    wr(5'd0, 8'h20);
    chk("R9 irq released", {7'b0, irq_n}, 8'h01);
    rdchk("R9 reg0 zero", 5'd0, 8'h00);
    rdchk("R9 reg3 zero", 5'd3, 8'h00);
    rdchk("R9 reg8 init", 5'd8, 8'h80);
  endtask

  task automatic t_abort;
    logic [7:0] r; logic z;
    wr(5'd2, 8'h33);
    frame(1'b0, 5'd2, 8'hCC, 13, r, z);
    rdchk("R10 aborted write", 5'd2, 8'h33);
    frame(1'b1, 5'd2, 8'h00, 9, r, z);
    chk("R10 sdo z after abort", {7'b0, sdo}, {7'b0, 1'bz});
    rdchk("R10 next frame clean", 5'd2, 8'h33);
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_write_read();
    t_out_of_range();
    t_status();
    t_irq();
    t_pdrst();
    t_softrst();
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule